// File: doc/BRIEF.md
# Register-Memory Pipelined Integer Core

This block is a six-stage in-order integer pipeline that issues one instruction per clock when nothing holds it back. Its instruction set has two shapes. A register-register instruction combines two registers. A register-memory instruction combines a register with a word read from data memory, where the word's address is a base register plus a signed offset. The stages, in order, are: fetch, decode with register read, an address ALU, data memory access, an operation ALU, and writeback. Because the operation ALU sits after the memory stage, an arithmetic instruction can consume a memory operand directly, with no separate load.

Instruction and data memories are external synchronous RAMs. Each returns read data one clock after it sees the address. Read-after-write dependencies are resolved by interlocking in the decode stage. The register file passes a same-cycle write through to its reads. Equality branches are resolved in the operation ALU, and a taken branch discards the four younger instructions.

Top module: `rm_pipe_core`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the fetch address is 0 and no data memory write is issued.
- R2: A store fetched from address A with no pending dependency drives its data memory write in the third cycle after its fetch address appears. Independent instructions issue one per cycle, so back-to-back stores write in consecutive cycles.
- R3: Register-register opcodes compute rd = rs1 op rs2 with 32-bit wraparound. The opcodes are add = 1, subtract = 2 (rs1 minus rs2), AND = 3 and OR = 4.
- R4: Register-memory opcodes compute rd = rs1 op MEM[rs2 + sext(offset)]. The opcodes are add = 5, subtract = 6, AND = 7 and OR = 8. Load = 9 writes rd = MEM[rs2 + sext(offset)]; its rs1 field affects neither the result nor the interlock.
- R5: Store = 10 writes rs1 to MEM[rs2 + sext(offset)]. The offset may be negative, and a store never writes a register.
- R6: Register 0 always reads as zero. A write to it is discarded, and naming it as a source never causes a stall.
- R7: When writeback writes a register in the same cycle that decode reads it, decode receives the new value. A consumer four instructions behind its producer therefore issues without stalling.
- R8: An instruction in decode that reads a register still to be written by an older instruction in the address ALU, memory or operation ALU stage is held, and a bubble is inserted. An immediately dependent instruction therefore issues three cycles late.
- R9: Branch-if-equal = 11 compares rs1 and rs2. When they are equal, fetch restarts at branchPC + sext(offset), and the four younger instructions are discarded without writing memory. When they differ, execution falls through. A taken branch adds four cycles over straight-line issue.
- R10: An instruction word has the opcode in bits 31:28, rd in 27:24, rs1 in 23:20, rs2 in 19:16 and a 16-bit offset in 15:0. Opcodes 0 and 12 to 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IAW | Instruction word address |
| imem_rdata | input | 32 | Instruction word, one cycle after its address |
| dmem_addr | output | DAW | Data word address |
| dmem_we | output | 1 | Data memory write enable |
| dmem_wdata | output | XLEN | Data memory write data |
| dmem_rdata | input | XLEN | Data memory read data, one cycle after its address |

## Verification
All results are observed as data memory writes. For each write, the bench records the clock cycle after reset release in which the write appears. Expected cycle gaps are derived by stepping each instruction through the stages by hand: a store fetched at cycle c writes at c+3; a dependent consumer waits until its producer reaches writeback; a taken branch adds four bubbles. The bench then compares the address, the data and the gap from the previous write against a table of these values. The first write falls at cycle 3, the load-interlocked writes come five cycles apart, and the writes that straddle the branch come seven cycles apart. Outputs are sampled on the falling edge, after each rising edge has settled.

// File: rtl/rmcore_pkg.sv
package rmcore_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_ADDM = 4'd5,
    OP_SUBM = 4'd6,
    OP_ANDM = 4'd7,
    OP_ORM  = 4'd8,
    OP_LOAD = 4'd9,
    OP_STOR = 4'd10,
    OP_BEQ  = 4'd11
  } opcode_e;

  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_OR} alufn_e;

  typedef struct packed {
    logic   wen;     // writes rd at writeback
    logic   mem_wr;  // writes data memory
    logic   mem_op;  // second ALU operand comes from memory
    logic   branch;  // equality branch
    logic   use_a;   // reads rs1
    logic   use_b;   // reads rs2
    alufn_e fn;
  } ctl_t;

  function automatic ctl_t decode_op(input logic [OPW-1:0] op);
    ctl_t c;
    c = '0;
    c.fn = FN_ADD;
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR: begin
        c.wen = 1'b1; c.use_a = 1'b1; c.use_b = 1'b1;
        c.fn = alufn_e'(op - 4'd1);
      end
      OP_ADDM, OP_SUBM, OP_ANDM, OP_ORM: begin
        c.wen = 1'b1; c.mem_op = 1'b1; c.use_a = 1'b1; c.use_b = 1'b1;
        c.fn = alufn_e'(op - 4'd5);
      end
      OP_LOAD: begin
        c.wen = 1'b1; c.mem_op = 1'b1; c.use_b = 1'b1;
      end
      OP_STOR: begin
        c.mem_wr = 1'b1; c.use_a = 1'b1; c.use_b = 1'b1;
      end
      OP_BEQ: begin
        c.branch = 1'b1; c.use_a = 1'b1; c.use_b = 1'b1;
      end
      default: c = c;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rmcore_regfile.sv
module rmcore_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RIDX-1:0] raddr_a,
  input  logic [RIDX-1:0] raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] regs [NREG];
  logic            wr_ok;

  assign wr_ok = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) regs[waddr] <= wdata;
  end

  always_comb begin
    if (raddr_a == '0)                 rdata_a = '0;
    else if (wr_ok && waddr == raddr_a) rdata_a = wdata;
    else                                rdata_a = regs[raddr_a];
    if (raddr_b == '0)                 rdata_b = '0;
    else if (wr_ok && waddr == raddr_b) rdata_b = wdata;
    else                                rdata_b = regs[raddr_b];
  end
endmodule

// File: rtl/rmcore_alu.sv
module rmcore_alu
  import rmcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alufn_e          fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/rmcore_hazard.sv
module rmcore_hazard #(
  parameter int RIDX  = 4,
  parameter int NBUSY = 3
) (
  input  logic                       chk_en,
  input  logic                       use_a,
  input  logic                       use_b,
  input  logic [RIDX-1:0]            src_a,
  input  logic [RIDX-1:0]            src_b,
  input  logic [NBUSY-1:0]           busy_v,
  input  logic [NBUSY-1:0][RIDX-1:0] busy_rd,
  output logic                       hold
);
  logic [NBUSY-1:0] hit;

  for (genvar g = 0; g < NBUSY; g++) begin : g_cmp
    assign hit[g] = busy_v[g] && (busy_rd[g] != '0) &&
                    ((use_a && busy_rd[g] == src_a) ||
                     (use_b && busy_rd[g] == src_b));
  end

  assign hold = chk_en && (|hit);
endmodule

// File: rtl/rm_pipe_core.sv
module rm_pipe_core
  import rmcore_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int OFFW = 16,
  parameter int IAW  = 16,
  parameter int DAW  = 16,
  localparam int RIDX = $clog2(NREG),
  localparam int IW   = OPW + 3 * RIDX + OFFW
) (
  input  logic            clk,
  input  logic            rst,
  output logic [IAW-1:0]  imem_addr,
  input  logic [IW-1:0]   imem_rdata,
  output logic [DAW-1:0]  dmem_addr,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata
);
  // fetch / decode
  logic [IAW-1:0]  pc_q, rf_pc;
  logic            rf_valid;
  logic [OPW-1:0]  f_op;
  logic [RIDX-1:0] f_rd, f_ra, f_rb;
  logic [OFFW-1:0] f_off;
  ctl_t            rf_ctl;
  logic [XLEN-1:0] rd_a, rd_b;
  logic            stall, haz, flush;

  // address ALU stage
  logic            a1_valid;
  ctl_t            a1_ctl;
  logic [RIDX-1:0] a1_rd;
  logic [XLEN-1:0] a1_a, a1_b, a1_imm;
  logic [IAW-1:0]  a1_pc;

  // memory stage
  logic            m_valid;
  ctl_t            m_ctl;
  logic [RIDX-1:0] m_rd;
  logic [XLEN-1:0] m_a, m_b;
  logic [DAW-1:0]  m_ea;
  logic [IAW-1:0]  m_tgt;

  // operation ALU stage
  logic            x_valid;
  ctl_t            x_ctl;
  logic [RIDX-1:0] x_rd;
  logic [XLEN-1:0] x_a, x_b, x_opa, x_opb, x_res;
  logic [IAW-1:0]  x_tgt;

  // writeback
  logic            w_we;
  logic [RIDX-1:0] w_rd;
  logic [XLEN-1:0] w_res;

  assign f_op   = imem_rdata[IW-1 -: OPW];
  assign f_rd   = imem_rdata[OFFW+3*RIDX-1 -: RIDX];
  assign f_ra   = imem_rdata[OFFW+2*RIDX-1 -: RIDX];
  assign f_rb   = imem_rdata[OFFW+RIDX-1 -: RIDX];
  assign f_off  = imem_rdata[OFFW-1:0];
  assign rf_ctl = decode_op(f_op);

  rmcore_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .we(w_we), .waddr(w_rd), .wdata(w_res),
    .raddr_a(f_ra), .raddr_b(f_rb), .rdata_a(rd_a), .rdata_b(rd_b)
  );

  rmcore_hazard #(.RIDX(RIDX), .NBUSY(3)) u_haz (
    .chk_en(rf_valid), .use_a(rf_ctl.use_a), .use_b(rf_ctl.use_b),
    .src_a(f_ra), .src_b(f_rb),
    .busy_v({x_valid && x_ctl.wen, m_valid && m_ctl.wen, a1_valid && a1_ctl.wen}),
    .busy_rd({x_rd, m_rd, a1_rd}),
    .hold(haz)
  );

  assign x_opa = x_ctl.use_a ? x_a : '0;
  assign x_opb = x_ctl.mem_op ? dmem_rdata : (x_ctl.use_b ? x_b : '0);

  rmcore_alu #(.XLEN(XLEN)) u_alu2 (
    .fn(x_ctl.fn), .a(x_opa), .b(x_opb), .y(x_res)
  );

  assign flush = x_valid && x_ctl.branch && (x_a == x_b);
  assign stall = haz && !flush;

  assign imem_addr  = stall ? rf_pc : pc_q;
  assign dmem_addr  = m_ea;
  assign dmem_wdata = m_a;
  assign dmem_we    = m_valid && m_ctl.mem_wr && !flush;

  // valid bits and program counter
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      rf_valid <= 1'b0;
      a1_valid <= 1'b0;
      m_valid  <= 1'b0;
      x_valid  <= 1'b0;
      w_we     <= 1'b0;
    end else begin
      x_valid <= m_valid && !flush;
      w_we    <= x_valid && x_ctl.wen;
      if (flush) begin
        pc_q     <= x_tgt;
        rf_valid <= 1'b0;
        a1_valid <= 1'b0;
        m_valid  <= 1'b0;
      end else begin
        m_valid <= a1_valid;
        if (stall) begin
          a1_valid <= 1'b0;
        end else begin
          pc_q     <= pc_q + IAW'(1);
          rf_valid <= 1'b1;
          a1_valid <= rf_valid;
        end
      end
    end
  end

  // pipeline data, no reset needed
  always_ff @(posedge clk) begin
    if (!stall) rf_pc <= pc_q;
    a1_ctl <= rf_ctl;
    a1_rd  <= f_rd;
    a1_a   <= rd_a;
    a1_b   <= rd_b;
    a1_imm <= {{(XLEN-OFFW){f_off[OFFW-1]}}, f_off};
    a1_pc  <= rf_pc;
    m_ctl  <= a1_ctl;
    m_rd   <= a1_rd;
    m_a    <= a1_a;
    m_b    <= a1_b;
    m_ea   <= DAW'(a1_b + a1_imm);
    m_tgt  <= a1_pc + IAW'(a1_imm);
    x_ctl  <= m_ctl;
    x_rd   <= m_rd;
    x_a    <= m_a;
    x_b    <= m_b;
    x_tgt  <= m_tgt;
    w_rd   <= x_rd;
    w_res  <= x_res;
  end
endmodule

// File: rtl/rmcore_chk.sv
module rmcore_chk #(
  parameter int IAW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           stall,
  input logic           flush,
  input logic           rf_valid,
  input logic           a1_valid,
  input logic           m_valid,
  input logic           x_valid,
  input logic           x_store,
  input logic           w_we,
  input logic           dmem_we,
  input logic [IAW-1:0] imem_addr
);
  // R2: without hold or redirect, the fetch address steps by one
  a_r2_seq_fetch: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush) |=> (stall || imem_addr == $past(imem_addr) + 1'b1));

  // R8: a held decode inserts a bubble into the address ALU stage
  a_r8_stall_bubble: assert property (@(posedge clk) disable iff (rst)
    stall |=> !a1_valid);

  // R8: while held, the fetch address repeats or resumes one past it
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (imem_addr == $past(imem_addr) || imem_addr == $past(imem_addr) + 1'b1));

  // R9: a taken branch empties every younger stage
  a_r9_flush_kills: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!rf_valid && !a1_valid && !m_valid && !dmem_we));

  // R9: the instruction in memory access during a redirect never writes
  a_r9_no_wrong_store: assert property (@(posedge clk) disable iff (rst)
    flush |-> !dmem_we);

  // R5: a store reaching the operation ALU never writes a register
  a_r5_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    (x_valid && x_store) |=> !w_we);
endmodule

bind rm_pipe_core rmcore_chk #(.IAW(IAW)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .flush(flush),
  .rf_valid(rf_valid), .a1_valid(a1_valid), .m_valid(m_valid),
  .x_valid(x_valid), .x_store(x_ctl.mem_wr), .w_we(w_we),
  .dmem_we(dmem_we), .imem_addr(imem_addr)
);

// File: tb/tb_rm_pipe_core.sv
module tb_rm_pipe_core;
  localparam int NEXP = 15;
  // {address, data, cycles since previous write (first: absolute cycle)}
  localparam logic [55:0] EXPV [NEXP] = '{
    {16'h0020, 32'h00000000, 8'd3},
    {16'h0021, 32'h0000000C, 8'd14},
    {16'h0022, 32'h00000002, 8'd1},
    {16'h0023, 32'h00000004, 8'd1},
    {16'h0024, 32'h0000000D, 8'd1},
    {16'h0025, 32'h0000000C, 8'd1},
    {16'h0026, 32'h00000002, 8'd1},
    {16'h0027, 32'h00000000, 8'd4},
    {16'h0028, 32'h00000005, 8'd1},
    {16'h0029, 32'h00000007, 8'd1},
    {16'h002B, 32'h00000005, 8'd7},
    {16'h000B, 32'h00000007, 8'd1},
    {16'h002C, 32'h00001234, 8'd5},
    {16'h002D, 32'hFFFFFFFE, 8'd5},
    {16'h002E, 32'h0000000C, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, dmem_addr;
  logic [31:0] imem_rdata = '0, dmem_rdata = '0, dmem_wdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          cyc = 0, nst = 0, checks = 0, fails = 0;
  bit          done = 1'b0;
  int          st_addr [32], st_data [32], st_cyc [32];

  always #2 clk = ~clk;

  rm_pipe_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata)
  );

  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[5:0]];
    if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
    dmem_rdata <= dmem[dmem_addr[5:0]];
    if (!rst) cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst && dmem_we && nst < 32) begin
      st_addr[nst] = int'(dmem_addr);
      st_data[nst] = int'(dmem_wdata);
      st_cyc[nst]  = cyc;
      nst++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [3:0] op, input logic [3:0] rd,
                     input logic [3:0] ra, input logic [3:0] rb, input logic [15:0] off);
    imem[idx] = {op, rd, ra, rb, off};
  endtask

  function automatic string tag(input int i);
    case (i)
      0: return "R2";
      1: return "R8";
      2, 3, 4, 13: return "R3";
      5, 6: return "R4";
      7: return "R6";
      8, 9: return "R7";
      10: return "R9";
      11: return "R5";
      12: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; end
    dmem[10] = 32'h1234; dmem[16] = 32'd5; dmem[17] = 32'd7;
    put(0, 10, 0, 0, 0, 16'h20);   // store r0
    put(1, 9, 1, 0, 0, 16'h10);    // r1 = 5
    put(2, 9, 2, 1, 0, 16'h11);    // r2 = 7, rs1 field names busy r1
    put(3, 1, 3, 1, 2, 0);         // r3 = 12
    put(4, 2, 4, 2, 1, 0);         // r4 = 2
    put(5, 3, 5, 3, 2, 0);         // r5 = 4
    put(6, 4, 6, 3, 1, 0);         // r6 = 13
    put(7, 5, 7, 1, 0, 16'h11);    // r7 = 12
    put(8, 6, 8, 2, 0, 16'h10);    // r8 = 2
    put(9, 10, 0, 3, 0, 16'h21);
    put(10, 10, 0, 4, 0, 16'h22);
    put(11, 10, 0, 5, 0, 16'h23);
    put(12, 10, 0, 6, 0, 16'h24);
    put(13, 10, 0, 7, 0, 16'h25);
    put(14, 10, 0, 8, 0, 16'h26);
    put(15, 7, 9, 6, 0, 16'h10);   // r9 = 5
    put(16, 8, 10, 4, 0, 16'h11);  // r10 = 7
    put(17, 1, 0, 1, 2, 0);        // write to r0 discarded
    put(18, 10, 0, 0, 0, 16'h27);
    put(19, 10, 0, 9, 0, 16'h28);
    put(20, 10, 0, 10, 0, 16'h29);
    put(21, 11, 0, 1, 1, 16'd4);   // taken to 25
    put(22, 10, 0, 1, 0, 16'h2A);
    put(23, 10, 0, 2, 0, 16'h2A);
    put(24, 10, 0, 3, 0, 16'h2A);
    put(25, 11, 0, 1, 2, 16'hFFFE); // not taken
    put(26, 10, 0, 1, 0, 16'h2B);
    put(27, 10, 0, 2, 3, 16'hFFFF); // addr 12-1
    put(28, 9, 12, 0, 3, 16'hFFFE); // r12 = MEM[10]
    put(29, 10, 0, 12, 0, 16'h2C);
    put(30, 2, 13, 1, 2, 0);        // r13 = -2
    put(31, 10, 0, 13, 0, 16'h2D);
    put(32, 15, 3, 1, 2, 0);        // unused opcode
    put(33, 10, 0, 3, 0, 16'h2E);
    put(34, 11, 0, 0, 0, 0);        // spin
    repeat (4) @(posedge clk);
    chk("R1", {16'h0, imem_addr}, 32'h0);
    chk("R1", {31'h0, dmem_we}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", {16'h0, imem_addr}, 32'h0);
    chk("R1", {31'h0, dmem_we}, 32'h0);
    repeat (200) @(negedge clk);
    for (int i = 0; i < NEXP; i++) begin
      if (i < nst) begin
        chk(tag(i), st_addr[i], {16'h0, EXPV[i][55:40]});
        chk(tag(i), st_data[i], EXPV[i][39:8]);
        chk(tag(i), st_cyc[i] - (i == 0 ? 0 : st_cyc[i-1]), {24'h0, EXPV[i][7:0]});
      end else begin
        chk(tag(i), nst, i + 1);
      end
    end
    chk("R9", nst, NEXP); // no write from discarded instructions
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule